// File: doc/BRIEF.md
# Six-Slot TDM Audio Serializer

This block sends six 24-bit audio samples per frame on a single serial data line. It makes its own bit clock and frame clock from a system clock and a tick input, `bclk_en`, that runs at twice the bit rate. Each tick toggles the bit clock. A frame is 256 bit-clock periods long. The frame clock is low for the first half of the frame and high for the second half. Three 32-period slots start at the beginning of each half, and the remaining 32 periods of each half carry zeros.

Each slot carries one sample, most significant bit first. The sample starts one bit-clock period after the slot boundary, and the bits after its least significant bit are zero. Serial data and frame clock change only on falling bit-clock edges, so a receiver can capture them on rising edges.

Upstream logic presents the six samples and pulses `load_i`. The block keeps that set in a holding register and moves it into the transmit register when the next frame starts. A load therefore never disturbs the frame on the wire.

Top module: `tdm6_serializer`

## Requirements
- R1: While reset is held and right after it, bit clock, frame clock and serial data are all low, and the bit-period count is 0.
- R2: The bit clock toggles on each system clock edge where `bclk_en` is high and holds its level otherwise. Frame clock and data also hold while ticks are absent.
- R3: A frame is 256 bit-clock periods. The frame clock reads low in periods 0 to 127 and high in periods 128 to 255, and the pattern repeats every frame.
- R4: Slot k (k = 0..5) takes its sample from `samples_i[24k+23:24k]`. Slots 0, 1 and 2 start at periods 0, 32 and 64. Slots 3, 4 and 5 start at periods 128, 160 and 192.
- R5: Within a slot, position 0 is zero and positions 1 to 24 carry sample bits 23 down to 0. Positions 25 to 31 are zero. Periods 96 to 127 and 224 to 255 are zero.
- R6: Serial data and frame clock change only on falling bit-clock edges. Both are stable across every rising edge.
- R7: A set loaded during a frame appears only from the next frame on. The frame in progress is not altered.
- R8: Until a frame has started after the first load, the data line is zero. A frame that starts with no new load since the previous frame repeats the previously sent set.
- R9: If several loads arrive within one frame, the last one is the set sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | Tick at twice the bit rate; each tick toggles the bit clock |
| load_i | input | 1 | Capture `samples_i` into the holding register |
| samples_i | input | 144 | Six 24-bit samples, slot k in bits 24k+23:24k |
| bclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Frame clock, low for the first half of the frame |
| sd_o | output | 1 | Serial data, valid on rising `bclk_o` |

## Verification
The hardest situation to reach is a load that lands in the middle of a frame already being sent. The frame on the wire must stay intact while the next one takes the new set. The stimulus loads one set partway into a frame, checks that frame bit by bit against the older set, and checks the following frame against the new set. A later frame takes two loads and also stops the ticks for a while, which shows that the last load wins and that all outputs freeze while ticks are absent.

// File: rtl/tdm6_serializer.sv
module tdm6_serializer #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int NSLOT    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bclk_en,
  input  logic                      load_i,
  input  logic [NSLOT*SAMPLE_W-1:0] samples_i,
  output logic                      bclk_o,
  output logic                      fs_o,
  output logic                      sd_o
);

  localparam int HALF_SLOTS = 4;
  localparam int FRAME_LEN  = 2 * HALF_SLOTS * SLOT_W;
  localparam int CW         = $clog2(FRAME_LEN);
  localparam int PW         = $clog2(SLOT_W);
  localparam int SW         = CW - 1 - PW;
  localparam int PER_HALF   = NSLOT / 2;
  localparam int SET_W      = NSLOT * SAMPLE_W;

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_nx;
  logic [SET_W-1:0] hold_q;
  logic [SET_W-1:0] frame_q;
  logic             hold_vld_q;
  logic             active_q;
  logic [PW-1:0]    pos;
  logic [SW-1:0]    sih;
  int               idx;
  logic             bit_nx;

  wire fall = bclk_en & bclk_o;
  wire wrap = fall & (cnt_nx == '0);

  assign cnt_nx = cnt_q + CW'(1);
  assign pos    = cnt_nx[PW-1:0];
  assign sih    = cnt_nx[CW-2:PW];

  always_comb begin
    idx    = (cnt_nx[CW-1] ? PER_HALF : 0) + int'(sih);
    bit_nx = 1'b0;
    if (int'(sih) < PER_HALF && int'(pos) >= 1 && int'(pos) <= SAMPLE_W)
      bit_nx = frame_q[idx*SAMPLE_W + SAMPLE_W - int'(pos)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_o     <= 1'b0;
      cnt_q      <= '0;
      fs_o       <= 1'b0;
      sd_o       <= 1'b0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      frame_q    <= '0;
      active_q   <= 1'b0;
    end else begin
      if (load_i) begin
        hold_q     <= samples_i;
        hold_vld_q <= 1'b1;
      end
      if (bclk_en) bclk_o <= ~bclk_o;
      if (fall) begin
        cnt_q <= cnt_nx;
        fs_o  <= cnt_nx[CW-1];
        sd_o  <= active_q & bit_nx;
      end
      if (wrap) begin
        frame_q  <= hold_q;
        active_q <= hold_vld_q;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |=> $stable(bclk_o) && $stable(fs_o) && $stable(sd_o));

  p_rise_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_o) |-> $stable(sd_o) && $stable(fs_o));

  p_fs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_o) |-> cnt_q == CW'(FRAME_LEN / 2));

  p_fs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_o) |-> cnt_q == '0);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !sd_o);

  p_gap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q[CW-2:PW]) >= PER_HALF) |-> !sd_o);

endmodule

// File: tb/tdm6_serializer_bench.sv
module tdm6_serializer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bclk_en = 1'b0;
  logic         load_i = 1'b0;
  logic [143:0] samples_i = '0;
  logic         bclk_o, fs_o, sd_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit en_gate = 1'b0;
  bit done = 1'b0;

  logic cap_fs [0:1279];
  logic cap_sd [0:1279];
  int   ridx = 0;
  logic prevb = 1'b0, prevsd = 1'b0, prevfs = 1'b0;

  logic [143:0] set_a, set_b, set_c, set_d;

  tdm6_serializer u_tdm6_serializer (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .load_i(load_i),
    .samples_i(samples_i), .bclk_o(bclk_o), .fs_o(fs_o), .sd_o(sd_o));

  always #5 clk = ~clk;

  always @(negedge clk) bclk_en <= en_gate ? ~bclk_en : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bclk_o && !prevb) begin
        checks++;
        if (sd_o !== prevsd || fs_o !== prevfs) begin
          errors++;
          $display("FAIL R6: change at rising edge %0d sd=%b/%b fs=%b/%b (expected equal)",
                   ridx, sd_o, prevsd, fs_o, prevfs);
        end
        if (ridx < 1280) begin
          cap_fs[ridx] <= fs_o;
          cap_sd[ridx] <= sd_o;
        end
        ridx <= ridx + 1;
      end
      prevb  <= bclk_o;
      prevsd <= sd_o;
      prevfs <= fs_o;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycle %0d reached (expected end before 200000)", cyc);
      finish_run();
    end
  end

  function automatic logic exp_bit(int c, logic [143:0] s);
    int start;
    for (int k = 0; k < 6; k++) begin
      start = (k < 3) ? 32 * k : 128 + 32 * (k - 3);
      if (c >= start + 1 && c <= start + 24)
        return s[k*24 + 24 - (c - start)];
    end
    return 1'b0;
  endfunction

  task automatic wait_rises(int n);
    while (ridx < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_set(logic [143:0] s);
    samples_i = s;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    samples_i = '0;
  endtask

  task automatic check_frame(int f, logic [143:0] s, string tag);
    logic e;
    wait_rises((f + 1) * 256);
    for (int c = 0; c < 256; c++) begin
      checks++;
      if (cap_fs[f*256+c] !== (c >= 128)) begin
        errors++;
        $display("FAIL R3: frame %0d period %0d fs=%b expected %b", f, c, cap_fs[f*256+c], c >= 128);
      end
      e = exp_bit(c, s);
      checks++;
      if (cap_sd[f*256+c] !== e) begin
        errors++;
        $display("FAIL %s: frame %0d period %0d sd=%b expected %b", tag, f, c, cap_sd[f*256+c], e);
      end
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (bclk_o !== 1'b0 || fs_o !== 1'b0 || sd_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: bclk=%b fs=%b sd=%b expected 0 0 0", bclk_o, fs_o, sd_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (bclk_o !== 1'b0 || fs_o !== 1'b0 || sd_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: after release without ticks bclk=%b fs=%b sd=%b expected 0 0 0", bclk_o, fs_o, sd_o);
    end
  endtask

  task automatic test_gate();
    logic b, f, d;
    en_gate = 1'b0;
    @(negedge clk);
    @(negedge clk);
    b = bclk_o; f = fs_o; d = sd_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      checks++;
      if (bclk_o !== b || fs_o !== f || sd_o !== d) begin
        errors++;
        $display("FAIL R2: outputs moved without ticks bclk=%b fs=%b sd=%b expected %b %b %b",
                 bclk_o, fs_o, sd_o, b, f, d);
      end
    end
    en_gate = 1'b1;
  endtask

  initial begin
    set_a = {24'hA5C3F0, 24'h123456, 24'h800001, 24'hFEDCBA, 24'h0F0F0F, 24'hC00003};
    set_b = {24'h000001, 24'h800000, 24'h555555, 24'hAAAAAA, 24'h7FFFFE, 24'h3C3C3C};
    set_c = {24'hFFFFFF, 24'h5A5A5A, 24'hFFFFFF, 24'h800000, 24'h000001, 24'hFFFFFF};
    set_d = {6{24'h9E3779}};
    test_reset();
    en_gate = 1'b1;
    wait_rises(50);
    load_set(set_a);
    check_frame(0, '0, "R8 idle");
    wait_rises(356);
    load_set(set_b);
    check_frame(1, set_a, "R4 R5 R7 slot data");
    check_frame(2, set_b, "R7 next set");
    wait_rises(778);
    test_gate();
    wait_rises(900);
    load_set(set_d);
    wait_rises(920);
    load_set(set_c);
    check_frame(3, set_b, "R8 repeat");
    check_frame(4, set_c, "R9 R5 last load");
    finish_run();
  end
endmodule